// File: doc/BRIEF.md
# Reloadable Underflow Timer Channel

This block is one 32-bit down-counting timer channel. While it is enabled, every pulse on the tick strobe lowers the count by one. The channel expires when a tick arrives while the count is already zero, which is an underflow past zero. A loaded value N therefore gives N+1 ticks from load to expiry. On expiry the channel either reloads from its reload register and keeps counting, or it stops. It can also raise a sticky pending flag and a one-cycle interrupt pulse.

Software sees three registers: the live count, the reload value and a control/status word. Each register has its own write strobe, and all three share one write-data bus. There is no stream interface, so there is no valid/ready pair and no back-pressure: every write strobe is taken in the cycle it is high, and the read values are always present.

Top module: `underflow_timer_chan`

## Requirements
- R1: After reset the count, the reload value, the control word and the interrupt output are all zero, and the channel is stopped.
- R2: While enable (control bit 0) is set, each tick lowers the count by one. While enable is clear, the count holds its value and ticks are ignored.
- R3: The channel expires when a tick arrives with enable set and a count of zero, so a count of N expires on the (N+1)-th tick.
- R4: On expiry with interrupt-enable (control bit 3) set, pending (control bit 4) becomes set and `irq_o` is high for exactly the following cycle. With interrupt-enable clear, neither happens.
- R5: Pending stays set until a control write carries a one in bit 4, which clears it. A control write with bit 4 at zero leaves pending unchanged.
- R6: On expiry with restart (control bit 1) set, the count is reloaded from the reload register and counting continues. With restart clear, the count stays at zero and enable is cleared.
- R7: A control write with load (bit 2) set copies the reload register into the count. Load always reads back as zero.
- R8: A write to the count register replaces the count. If enable is set, counting continues from the new value.
- R9: The control word reads back enable in bit 0, restart in bit 1, zero in bit 2, interrupt-enable in bit 3 and pending in bit 4. Bits 5 and up read as zero and writes to them have no effect.
- R10: When a register write and an expiry fall in the same cycle, the written count wins over the reload, and setting pending wins over any control write in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick strobe |
| wr_cnt_i | input | 1 | Write strobe for the count register |
| wr_rld_i | input | 1 | Write strobe for the reload register |
| wr_ctl_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data shared by all registers |
| cnt_o | output | 32 | Live count |
| rld_o | output | 32 | Reload value |
| ctl_o | output | 32 | Control/status word |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Every result is due one clock edge after its stimulus. The count, reload and control word are registers that take their new value at that edge, and `irq_o` is registered from the same expiry condition that sets pending, so it rises at the same edge. The bench drives each stimulus just after a falling edge, lets a single rising edge pass, and samples all outputs at the next falling edge. The pulse check then waits one more cycle to confirm that `irq_o` has dropped. Cases where a write and an expiry fall in the same cycle are driven together on one edge, so the priority rules are checked at that edge.

// File: rtl/uft_pkg.sv
package uft_pkg;
  // Control word bit positions; software decodes these.
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned RS_BIT   = 1;
  localparam int unsigned LD_BIT   = 2;
  localparam int unsigned IE_BIT   = 3;
  localparam int unsigned PEND_BIT = 4;
  localparam int unsigned CTL_USED = 5;
endpackage

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wr_data,
  input  logic          expire,
  output logic          en,
  output logic          rs,
  output logic          ie,
  output logic          pend,
  output logic          irq
);
  logic clr_pend;
  logic set_pend;

  assign clr_pend = wr_ctl & wr_data[PEND_BIT];
  assign set_pend = expire & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      rs   <= 1'b0;
      ie   <= 1'b0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en <= wr_data[EN_BIT];
        rs <= wr_data[RS_BIT];
        ie <= wr_data[IE_BIT];
      end else if (expire && !rs) begin
        en <= 1'b0;
      end
      // a set from expiry beats a clear written in the same cycle
      pend <= set_pend | (pend & ~clr_pend);
      irq  <= set_pend;
    end
  end

  // R4
  irq_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  // R5
  pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !(expire && ie)) |=> !pend);

  // R6
  oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rs && !wr_ctl) |=> !en);
endmodule

// File: rtl/uft_count.sv
module uft_count
  import uft_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          rs,
  input  logic          wr_cnt,
  input  logic          wr_rld,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] rld,
  output logic          expire
);
  logic load_req;
  logic at_zero;

  assign load_req = wr_ctl & wr_data[LD_BIT];
  assign at_zero  = (cnt == '0);
  assign expire   = en & tick & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
    end else begin
      if (wr_rld) rld <= wr_data;
      if (wr_cnt) begin
        cnt <= wr_data;
      end else if (load_req) begin
        cnt <= rld;
      end else if (expire) begin
        if (rs) cnt <= rld;
      end else if (en && tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_cnt && !load_req) |=> $stable(cnt));

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !at_zero && !wr_cnt && !load_req) |=> (cnt == $past(cnt) - 1'b1));

  // R7
  load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !wr_cnt) |=> (cnt == $past(rld)));

  // R10
  write_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && expire) |=> (cnt == $past(wr_data)));
endmodule

// File: rtl/underflow_timer_chan.sv
module underflow_timer_chan
  import uft_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_cnt_i,
  input  logic          wr_rld_i,
  input  logic          wr_ctl_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic [DW-1:0] ctl_o,
  output logic          irq_o
);
  localparam int unsigned PAD_W = DW - CTL_USED;

  logic en, rs, ie, pend, expire;

  uft_count #(.DW(DW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_i),
    .en      (en),
    .rs      (rs),
    .wr_cnt  (wr_cnt_i),
    .wr_rld  (wr_rld_i),
    .wr_ctl  (wr_ctl_i),
    .wr_data (wr_data_i),
    .cnt     (cnt_o),
    .rld     (rld_o),
    .expire  (expire)
  );

  uft_ctrl #(.DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctl  (wr_ctl_i),
    .wr_data (wr_data_i),
    .expire  (expire),
    .en      (en),
    .rs      (rs),
    .ie      (ie),
    .pend    (pend),
    .irq     (irq_o)
  );

  // load reads as zero; unused upper bits read as zero
  assign ctl_o = {{PAD_W{1'b0}}, pend, ie, 1'b0, rs, en};

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (cnt_o == '0 && ctl_o == '0 && !irq_o));
endmodule

// File: tb/underflow_timer_chan_tb_top.sv
module underflow_timer_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, wr_cnt_i = 1'b0, wr_rld_i = 1'b0, wr_ctl_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] cnt_o, rld_o, ctl_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  underflow_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_cnt_i(wr_cnt_i),
    .wr_rld_i(wr_rld_i), .wr_ctl_i(wr_ctl_i), .wr_data_i(wr_data_i),
    .cnt_o(cnt_o), .rld_o(rld_o), .ctl_o(ctl_o), .irq_o(irq_o)
  );

  // op: 0 idle, 1 tick, 2 count write, 3 reload write, 4 control write
  // fields: op[79:76] data[75:44] count[43:12] ctl[11:4] irq[3:0]
  localparam int NV = 21;
  localparam logic [79:0] VEC [NV] = '{
    {4'd3, 32'd2,          32'd2 - 32'd2, 8'h00, 4'd0},
    {4'd4, 32'h0F,         32'd2, 8'h0B, 4'd0},
    {4'd1, 32'd0,          32'd1, 8'h0B, 4'd0},
    {4'd1, 32'd0,          32'd0, 8'h0B, 4'd0},
    {4'd0, 32'd0,          32'd0, 8'h0B, 4'd0},
    {4'd1, 32'd0,          32'd2, 8'h1B, 4'd1},
    {4'd0, 32'd0,          32'd2, 8'h1B, 4'd0},
    {4'd4, 32'h0B,         32'd2, 8'h1B, 4'd0},
    {4'd4, 32'h1B,         32'd2, 8'h0B, 4'd0},
    {4'd4, 32'h09,         32'd2, 8'h09, 4'd0},
    {4'd1, 32'd0,          32'd1, 8'h09, 4'd0},
    {4'd1, 32'd0,          32'd0, 8'h09, 4'd0},
    {4'd1, 32'd0,          32'd0, 8'h18, 4'd1},
    {4'd1, 32'd0,          32'd0, 8'h18, 4'd0},
    {4'd2, 32'd5,          32'd5, 8'h18, 4'd0},
    {4'd1, 32'd0,          32'd5, 8'h18, 4'd0},
    {4'd4, 32'hFFFF_FFE1,  32'd5, 8'h11, 4'd0},
    {4'd1, 32'd0,          32'd4, 8'h11, 4'd0},
    {4'd2, 32'd1,          32'd1, 8'h11, 4'd0},
    {4'd1, 32'd0,          32'd0, 8'h11, 4'd0},
    {4'd1, 32'd0,          32'd0, 8'h10, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_drive();
    tick_i = 0; wr_cnt_i = 0; wr_rld_i = 0; wr_ctl_i = 0; wr_data_i = '0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_drive();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt_o, 0);
    chk("R1 rld", rld_o, 0);
    chk("R1 ctl", ctl_o, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      v = VEC[i];
      wr_data_i = v[75:44];
      case (v[79:76])
        4'd1: tick_i = 1;
        4'd2: wr_cnt_i = 1;
        4'd3: wr_rld_i = 1;
        4'd4: wr_ctl_i = 1;
        default: ;
      endcase
      step();
      chk($sformatf("R2/R3/R6/R7/R8 count vec %0d", i), cnt_o, v[43:12]);
      chk($sformatf("R4/R5/R9 ctl vec %0d", i), ctl_o, {24'd0, v[11:4]});
      chk($sformatf("R4 irq vec %0d", i), {31'd0, irq_o}, {28'd0, v[3:0]});
    end
    chk("R7 reload kept", rld_o, 2);

    // R10 count write beats expiry-driven reload
    wr_rld_i = 1; wr_data_i = 32'd7; step();
    wr_cnt_i = 1; wr_data_i = 32'd0; step();
    wr_ctl_i = 1; wr_data_i = 32'h1B; step();
    chk("R5 clear by one", ctl_o, 32'h0B);
    tick_i = 1; wr_cnt_i = 1; wr_data_i = 32'd9; step();
    chk("R10 written count wins", cnt_o, 9);
    chk("R10 expiry still sets pending", ctl_o, 32'h1B);
    chk("R4 irq on expiry", {31'd0, irq_o}, 1);
    step();
    chk("R4 irq single cycle", {31'd0, irq_o}, 0);

    // R10 pending set beats a clearing control write
    wr_cnt_i = 1; wr_data_i = 32'd0; step();
    tick_i = 1; wr_ctl_i = 1; wr_data_i = 32'h1B; step();
    chk("R10 pending set wins", ctl_o, 32'h1B);
    chk("R6 restart reload", cnt_o, 7);
    chk("R10 irq", {31'd0, irq_o}, 1);

    // R1 reset again mid-run
    rst_n = 0; step();
    chk("R1 count after reset", cnt_o, 0);
    chk("R1 ctl after reset", ctl_o, 0);
    chk("R1 reload after reset", rld_o, 0);
    rst_n = 1;
    tick_i = 1; step();
    chk("R1 stopped after reset", cnt_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule